// File: doc/BRIEF.md
# Runaway-Program Watchdog with Selectable Timeout

This block watches for firmware that has lost control. Once armed, it counts main-clock periods, and firmware must keep restarting it inside a chosen interval. If the interval runs out with no restart, the block raises one request. That request is either a system reset request or a non-maskable interrupt request, as firmware chose when it armed the block.

Firmware reaches the block through a small write port with two registers. The control register holds a start/restart strobe, an enable bit and an action bit. The interval register holds a 3-bit timeout code.

A free-running prescaler divides the main clock, and a tick counter behind it measures the interval. A restart does not touch the prescaler. The first tick after a restart can therefore come early, so an expiry may arrive up to one prescaler period before the nominal interval.

Three status inputs gate the count. While the CPU idles in its halt state, counting goes on. While the clock is stopped, or while the CPU runs from the slow subsystem clock, both the prescaler and the count hold their values. The parameter `PRESCALE_LOG2` must be smaller than `BASE_LOG2`.

Top module: `loop_watchdog`

## Requirements
- R1: While reset is applied, and after reset is released, both request outputs are 0. Both readback buses are 0, and the timeout code is 0.
- R2: A write with `wr_sel_i`=1 loads the timeout code from `wr_data_i[2:0]`. A write with `wr_sel_i`=0 goes to the control register. In the control register, bit 7 is the start/restart strobe, bit 4 is the enable and bit 3 is the action. The control readback shows enable on bit 4 and action on bit 3, and bit 7 always reads 0.
- R3: Timeout code k gives an interval of 2^T main-clock periods. T = BASE_LOG2+k for k = 0..6, and T = BASE_LOG2+8 for k = 7. Let d be the number of rising edges from the edge that accepts the start write to the edge that raises the request. Then 2^T−2^PRESCALE_LOG2+1 ≤ d ≤ 2^T.
- R4: A request lasts exactly one cycle. The count then restarts from zero, so with no further write the next request comes exactly 2^T edges later.
- R5: Action bit 1 sends the expiry to `rst_req_o`. Action bit 0 sends it to `nmi_req_o`. The two outputs are never high together.
- R6: Writing 1 to bit 7 while the watchdog is running clears the count and restarts the interval from that write. Writing 0 to bit 7 has no effect.
- R7: Once bit 7 has been written as 1, the running state, the enable and the action can no longer be changed, and only a reset clears them. Writes to the timeout code are ignored while the watchdog is running.
- R8: If the enable was 0 when the watchdog started, no request is ever raised.
- R9: Asserting `halt_i` has no effect on the interval.
- R10: Each cycle with `stop_i` high freezes both the prescaler and the count, which delays expiry by exactly one cycle.
- R11: Each cycle with `subclk_i` high freezes both the prescaler and the count, which delays expiry by exactly one cycle.
- R12: A restart write that falls in the same cycle as an expiry takes priority. No request is raised, and the new interval starts at that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_sel_i | input | 1 | 0 = control register, 1 = timeout code register |
| wr_data_i | input | 8 | Write data |
| halt_i | input | 1 | CPU is in the halt state (counting continues) |
| stop_i | input | 1 | Clock stopped (counting frozen) |
| subclk_i | input | 1 | CPU runs from the subsystem clock (counting frozen) |
| mode_rd_o | output | 8 | Control readback: enable on bit 4, action on bit 3, all other bits 0 |
| sel_rd_o | output | 3 | Timeout code readback |
| rst_req_o | output | 1 | One-cycle system reset request |
| nmi_req_o | output | 1 | One-cycle non-maskable interrupt request |

## Verification
A restart write and an expiry can land on the same clock edge. To provoke this, the bench first runs in interrupt mode and records the cycle of one request. Because the count restarts after every expiry, the next expiry edge is known exactly, and the bench places a restart write on that edge. The scoreboard then requires no request on that edge and expects the next request exactly one full interval after the write. A request on the collision edge is reported as unexpected.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int unsigned CtlStrobeBit = 7;
  localparam int unsigned CtlEnableBit = 4;
  localparam int unsigned CtlActionBit = 3;

  // Extra doubling steps above the base interval for each timeout code.
  // The ladder skips one step at its top code.
  function automatic logic [3:0] step_shift(input logic [2:0] code);
    return (code == 3'd7) ? 4'd8 : {1'b0, code};
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned PRESCALE_LOG2 = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic tick_o
);

  generate
    if (PRESCALE_LOG2 == 0) begin : g_bypass
      assign tick_o = adv_i;
    end else begin : g_div
      logic [PRESCALE_LOG2-1:0] div_q, div_d;

      always_comb begin
        div_d = div_q;
        if (adv_i) div_d = div_q + 1'b1;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
      end

      assign tick_o = adv_i & (&div_q);

      // R10 R11: a frozen prescaler keeps its phase
      a_r10_prescaler_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !adv_i |=> $stable(div_q));
    end
  endgenerate

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic       run_o,
  output logic       en_o,
  output logic       act_o,
  output logic [2:0] sel_o,
  output logic       restart_o
);

  logic       run_q, run_d;
  logic       en_q, en_d;
  logic       act_q, act_d;
  logic [2:0] sel_q, sel_d;
  logic       ctl_wr;
  logic       unused_bits;

  assign ctl_wr      = wr_en_i & ~wr_sel_i;
  assign restart_o   = ctl_wr & wr_data_i[CtlStrobeBit];
  assign unused_bits = ^wr_data_i[6:5];

  always_comb begin
    run_d = run_q;
    en_d  = en_q;
    act_d = act_q;
    sel_d = sel_q;
    if (wr_en_i && wr_sel_i && !run_q) sel_d = wr_data_i[2:0];
    if (ctl_wr && !run_q) begin
      en_d  = wr_data_i[CtlEnableBit];
      act_d = wr_data_i[CtlActionBit];
    end
    if (restart_o) run_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      en_q  <= 1'b0;
      act_q <= 1'b0;
      sel_q <= 3'd0;
    end else begin
      run_q <= run_d;
      en_q  <= en_d;
      act_q <= act_d;
      sel_q <= sel_d;
    end
  end

  assign run_o = run_q;
  assign en_o  = en_q;
  assign act_o = act_q;
  assign sel_o = sel_q;

  // R7: settings are locked once running
  a_r7_locked_when_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> run_q && $stable(en_q) && $stable(act_q) && $stable(sel_q));

  // R6: a zero strobe never starts the watchdog
  a_r6_zero_strobe_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q && !(ctl_wr && wr_data_i[CtlStrobeBit]) |=> !run_q);

endmodule

// File: rtl/wdt_timeout.sv
module wdt_timeout
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_LOG2     = 12,
  parameter int unsigned PRESCALE_LOG2 = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       armed_i,
  input  logic       tick_i,
  input  logic       restart_i,
  input  logic [2:0] sel_i,
  input  logic       act_i,
  output logic       rst_req_o,
  output logic       nmi_req_o
);

  localparam int unsigned CntW = BASE_LOG2 + 8 - PRESCALE_LOG2;
  localparam int unsigned Sh0  = BASE_LOG2 - PRESCALE_LOG2;

  logic [CntW-1:0] cnt_q, cnt_d, limit_m1;
  logic            expire;
  logic            rst_q, rst_d, nmi_q, nmi_d;

  always_comb begin
    // Top code overflows the shift to zero, giving an all-ones limit
    limit_m1 = (CntW'(1) << (Sh0 + int'(step_shift(sel_i)))) - CntW'(1);
    expire   = armed_i & tick_i & ~restart_i & (cnt_q == limit_m1);
    cnt_d    = cnt_q;
    if (restart_i)                cnt_d = '0;
    else if (armed_i && tick_i)   cnt_d = expire ? '0 : cnt_q + 1'b1;
    rst_d = expire & act_i;
    nmi_d = expire & ~act_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rst_q <= rst_d;
      nmi_q <= nmi_d;
    end
  end

  assign rst_req_o = rst_q;
  assign nmi_req_o = nmi_q;

  // R4: request is a single-cycle pulse
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_q || nmi_q) |=> !rst_q && !nmi_q);

  // R12: restart wins over a coincident expiry
  a_r12_restart_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !rst_q && !nmi_q && (cnt_q == '0));

  // R10 R11: no tick, no change in count
  a_r10_r11_count_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !restart_i |=> $stable(cnt_q));

endmodule

// File: rtl/loop_watchdog.sv
module loop_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_LOG2     = 12,
  parameter int unsigned PRESCALE_LOG2 = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       wr_sel_i,
  input  logic [7:0] wr_data_i,
  input  logic       halt_i,
  input  logic       stop_i,
  input  logic       subclk_i,
  output logic [7:0] mode_rd_o,
  output logic [2:0] sel_rd_o,
  output logic       rst_req_o,
  output logic       nmi_req_o
);

  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic       active, tick;
  logic       run, en, act, restart;
  logic       unused_halt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // Halt keeps the main clock running, so it does not gate counting
  assign unused_halt = halt_i;
  assign active      = ~stop_i & ~subclk_i;

  wdt_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .run_o     (run),
    .en_o      (en),
    .act_o     (act),
    .sel_o     (sel_rd_o),
    .restart_o (restart)
  );

  wdt_prescaler #(.PRESCALE_LOG2(PRESCALE_LOG2)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .adv_i  (active),
    .tick_o (tick)
  );

  wdt_timeout #(.BASE_LOG2(BASE_LOG2), .PRESCALE_LOG2(PRESCALE_LOG2)) u_tmo (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .armed_i   (run & en),
    .tick_i    (tick),
    .restart_i (restart),
    .sel_i     (sel_rd_o),
    .act_i     (act),
    .rst_req_o (rst_req_o),
    .nmi_req_o (nmi_req_o)
  );

  assign mode_rd_o = {3'b000, en, act, 3'b000};

  // R5: never both requests
  a_r5_exclusive: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(rst_req_o && nmi_req_o));

  // R8: a disarmed watchdog stays silent
  a_r8_disarmed_quiet: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(run && en) |=> !rst_req_o && !nmi_req_o);

  // R10 R11: no expiry on a frozen edge
  a_r10_r11_frozen_no_req: assert property (@(posedge clk_i) disable iff (!rst_n)
    (stop_i || subclk_i) |=> !rst_req_o && !nmi_req_o);

endmodule

// File: tb/loop_watchdog_bench.sv
`timescale 1ns/1ps
module loop_watchdog_bench;

  localparam int BASE = 4;
  localparam int PRE  = 1;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       wr_en, wr_sel;
  logic [7:0] wr_data;
  logic       halt, stop, subclk;
  logic [7:0] mode_rd;
  logic [2:0] sel_rd;
  logic       rst_req, nmi_req;

  always #2.5 clk = ~clk;

  loop_watchdog #(.BASE_LOG2(BASE), .PRESCALE_LOG2(PRE)) u_loop_watchdog (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .halt_i(halt), .stop_i(stop), .subclk_i(subclk),
    .mode_rd_o(mode_rd), .sel_rd_o(sel_rd), .rst_req_o(rst_req), .nmi_req_o(nmi_req)
  );

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int last_pulse = -1;
  int q_lo[$];
  int q_hi[$];
  int q_kind[$];
  string q_tag[$];
  string cur_tag = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Monitor: kind 1 = reset request, 2 = interrupt request, 3 = both
  always @(negedge clk) begin
    int kind;
    kind = (rst_req ? 1 : 0) + (nmi_req ? 2 : 0);
    if (kind != 0) begin
      last_pulse = cyc;
      if (q_lo.size() == 0) begin
        chk(1'b0, cur_tag, "unexpected request kind", kind, 0);
      end else begin
        chk(kind == q_kind[0], q_tag[0], "request kind", kind, q_kind[0]);
        chk(cyc >= q_lo[0] && cyc <= q_hi[0], q_tag[0], "request cycle", cyc, q_hi[0]);
        void'(q_lo.pop_front()); void'(q_hi.pop_front());
        void'(q_kind.pop_front()); void'(q_tag.pop_front());
      end
    end else if (q_lo.size() > 0 && cyc > q_hi[0]) begin
      chk(1'b0, q_tag[0], "missing request by cycle", cyc, q_hi[0]);
      void'(q_lo.pop_front()); void'(q_hi.pop_front());
      void'(q_kind.pop_front()); void'(q_tag.pop_front());
    end
  end

  task automatic expect_req(input int kind, input int lo, input int hi, input string tag);
    q_kind.push_back(kind); q_lo.push_back(lo); q_hi.push_back(hi); q_tag.push_back(tag);
  endtask

  // Called at a negedge; the write is taken at the next rising edge
  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input int maxc);
    int n = 0;
    while (q_lo.size() > 0 && n < maxc) begin
      @(negedge clk);
      n++;
    end
    tick(2);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; wr_en = 1'b0; halt = 1'b0; stop = 1'b0; subclk = 1'b0;
    tick(3);
    rst_ni = 1'b1;
    tick(3);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int w, x, tt;
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00;
    halt = 1'b0; stop = 1'b0; subclk = 1'b0; rst_ni = 1'b0;
    tick(2);
    // R1: state during and after reset
    chk(rst_req == 1'b0, "R1", "rst_req in reset", rst_req, 0);
    chk(nmi_req == 1'b0, "R1", "nmi_req in reset", nmi_req, 0);
    chk(mode_rd == 8'h00, "R1", "mode readback in reset", mode_rd, 0);
    chk(sel_rd == 3'd0, "R1", "code readback in reset", sel_rd, 0);
    rst_ni = 1'b1;
    tick(4);
    chk(!rst_req && !nmi_req, "R1", "requests after reset", rst_req, 0);

    // R2 R3: every timeout code, reset action
    for (int k = 0; k < 8; k++) begin
      do_reset();
      cur_tag = "R3";
      tt = 1 << ((k == 7) ? BASE + 8 : BASE + k);
      wr(1'b1, 8'(k));
      chk(sel_rd == 3'(k), "R2", "timeout code readback", sel_rd, k);
      wr(1'b0, 8'h98);
      w = cyc;
      chk(mode_rd == 8'h18, "R2", "mode readback with strobe reading 0", mode_rd, 8'h18);
      expect_req(1, w + tt - (1 << PRE) + 1, w + tt, "R3");
      drain(tt + 10);
      if (k == 0) begin
        // R4: periodic repeat exactly one interval later
        expect_req(1, last_pulse + tt, last_pulse + tt, "R4");
        drain(tt + 10);
      end
    end

    // R5: interrupt action, then R12 collision on a known expiry edge
    do_reset();
    cur_tag = "R5";
    wr(1'b0, 8'h90);
    w = cyc;
    expect_req(2, w + 15, w + 16, "R5");
    drain(40);
    x = last_pulse;
    cur_tag = "R12";
    while (cyc < x + 15) @(negedge clk);
    wr(1'b0, 8'h80);
    w = cyc;
    chk(w == x + 16, "R12", "restart lands on expiry edge", w, x + 16);
    expect_req(2, w + 16, w + 16, "R12");
    drain(40);

    // R6 R7: restart before expiry, zero strobe, locked settings
    do_reset();
    cur_tag = "R6";
    wr(1'b1, 8'd2);
    wr(1'b0, 8'h98);
    tick(40);
    wr(1'b0, 8'h00);
    chk(mode_rd == 8'h18, "R7", "mode locked after start", mode_rd, 8'h18);
    wr(1'b1, 8'd5);
    chk(sel_rd == 3'd2, "R7", "code locked while running", sel_rd, 2);
    tick(3);
    wr(1'b0, 8'h80);
    w = cyc;
    expect_req(1, w + 63, w + 64, "R6");
    drain(100);

    // R8: started with enable clear
    do_reset();
    cur_tag = "R8";
    wr(1'b0, 8'h80);
    tick(40);
    wr(1'b0, 8'h98);
    chk(mode_rd == 8'h00, "R8", "enable stays clear", mode_rd, 0);
    tick(100);
    chk(!rst_req && !nmi_req, "R8", "no request while disabled", rst_req, 0);

    // R9: halt does not alter the interval
    do_reset();
    cur_tag = "R9";
    halt = 1'b1;
    wr(1'b0, 8'h98);
    w = cyc;
    expect_req(1, w + 15, w + 16, "R9");
    drain(40);
    halt = 1'b0;

    // R10: stop freezes 20 cycles
    do_reset();
    cur_tag = "R10";
    wr(1'b1, 8'd1);
    wr(1'b0, 8'h98);
    w = cyc;
    expect_req(1, w + 51, w + 52, "R10");
    tick(10);
    stop = 1'b1;
    tick(20);
    stop = 1'b0;
    drain(80);

    // R11: subsystem clock freezes 15 cycles
    do_reset();
    cur_tag = "R11";
    wr(1'b1, 8'd1);
    wr(1'b0, 8'h98);
    w = cyc;
    expect_req(1, w + 46, w + 47, "R11");
    tick(7);
    subclk = 1'b1;
    tick(15);
    subclk = 1'b0;
    drain(80);

    chk(q_lo.size() == 0, "R3", "scoreboard empty at end", q_lo.size(), 0);
    summary();
    $finish;
  end

endmodule